// File: doc/BRIEF.md
# Send-Path Level Scaling and Center Clipping Stage

This block sits on the send side of a voice echo canceller and handles one linear sample at a time. An incoming near-end sample is first scaled down in 6 dB steps. It is then registered and offered to the adaptive canceller on a dedicated output. The canceller returns its residual. The stage picks the residual or, while the canceller is bypassed, the scaled near-end sample. It optionally replaces very quiet values with the smallest positive code, then scales the result up in 6 dB steps with saturation.

Bypass does not skip the level settings. A bit-exact through path needs both the input and the output level codes at their 0 dB value. Raising the bypass input also asks the canceller to wipe its filter coefficients through a registered clear output. Each 6 dB step is one arithmetic shift. The quiet-signal threshold is a parameter given as a linear magnitude for the chosen sample width.

Top module: `slp_send_level`

## Requirements
- R1: The input scale code selects the shift applied to the near-end sample: 2'b00 gives 0 dB (no shift), 2'b01 gives -6 dB (arithmetic right shift by 1), 2'b10 gives -12 dB (arithmetic right shift by 2), and the reserved 2'b11 behaves as 0 dB. Shifts round toward minus infinity, and the scaled sample appears on `fwd_data_o` with `fwd_valid_o` high one clock after `sin_valid_i`.
- R2: The output boost code selects the output shift: 2'b00 gives 0 dB, 2'b01 gives +6 dB (left shift by 1), 2'b10 gives +12 dB (left shift by 2), and the reserved 2'b11 behaves as 0 dB.
- R3: With `GAIN_SAT`=1, a boosted value outside the signed range is held at the largest positive or most negative code, and is never wrapped.
- R4: While `bypass_i` is high, the output takes the scaled near-end sample, `res_valid_i` and `res_data_i` are ignored, and both level codes still apply.
- R5: While `bypass_i` is low, the output takes `res_data_i`, and `sout_valid_o` goes high one clock after `res_valid_i`. A near-end sample alone produces no output.
- R6: With `clip_en_i` high, a selected sample whose magnitude is below `CLIP_LEVEL` (default 46) is replaced by +1 before the output boost. A magnitude equal to `CLIP_LEVEL` passes unchanged.
- R7: With `clip_en_i` low, small samples, zero included, pass without clipping.
- R8: `coef_clear_o` goes high one clock after `bypass_i` rises and stays high while `bypass_i` stays high. It falls one clock after `bypass_i` falls.
- R9: While `rst_n` is low, every output is zero and both valid outputs are low.
- R10: In bypass, a near-end sample reaches `sout_data_o` two clocks after `sin_valid_i`. `sout_valid_o` is still low one clock after that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sin_valid_i | input | 1 | Near-end sample strobe |
| sin_data_i | input | DATA_W | Near-end signed sample |
| att_code_i | input | 2 | Input scale code |
| gain_code_i | input | 2 | Output boost code |
| clip_en_i | input | 1 | Center clipping enable, active high |
| bypass_i | input | 1 | Canceller bypass (through path) |
| fwd_valid_o | output | 1 | Scaled near-end sample strobe to canceller |
| fwd_data_o | output | DATA_W | Scaled near-end sample to canceller |
| res_valid_i | input | 1 | Residual strobe from canceller |
| res_data_i | input | DATA_W | Residual signed sample from canceller |
| coef_clear_o | output | 1 | Coefficient clear request to canceller |
| sout_valid_o | output | 1 | Send output strobe |
| sout_data_o | output | DATA_W | Send output signed sample |

## Verification
The bench builds the block with its defaults: 16-bit samples, a clipping threshold of 46 and saturating gain. At this width, ±10000 boosted by 12 dB and 8192 boosted by 12 dB all exceed the signed range, so both saturation rails are reached. The threshold is small enough that the values 45 and 46 on either side of it can be driven directly. Odd negative inputs show the downward rounding of the attenuator. The reserved codes are applied in both level fields, and clipping is exercised on both the bypass and residual routes.

// File: rtl/slp_pkg.sv
package slp_pkg;

   typedef enum logic [1:0] {
      LVL_0DB  = 2'b00,
      LVL_6DB  = 2'b01,
      LVL_12DB = 2'b10,
      LVL_RSVD = 2'b11
   } lvl_code_e;

   localparam int unsigned MAX_STEP = 2;

   function automatic int unsigned lvl_steps(input logic [1:0] code);
      case (lvl_code_e'(code))
         LVL_6DB:  lvl_steps = 1;
         LVL_12DB: lvl_steps = 2;
         default:  lvl_steps = 0;
      endcase
   endfunction

endpackage

// File: rtl/slp_atten.sv
module slp_atten
   import slp_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vld_i,
   input  logic signed [DATA_W-1:0] data_i,
   input  logic [1:0]               code_i,
   output logic                     vld_o,
   output logic signed [DATA_W-1:0] data_o
);

   logic signed [DATA_W-1:0] scaled;
   logic signed [DATA_W-1:0] data_q;
   logic                     vld_q;

   always_comb begin
      scaled = data_i >>> lvl_steps(code_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         data_q <= '0;
      end else begin
         vld_q <= vld_i;
         if (vld_i) begin
            data_q <= scaled;
         end
      end
   end

   assign vld_o  = vld_q;
   assign data_o = data_q;

   AST_ATT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |=> vld_o); // R1

   AST_ATT_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |=> (data_o[DATA_W-1] == $past(data_i[DATA_W-1]))); // R1

endmodule

// File: rtl/slp_clip.sv
module slp_clip #(
   parameter int DATA_W     = 16,
   parameter int CLIP_LEVEL = 46
) (
   input  logic                     en_i,
   input  logic signed [DATA_W-1:0] data_i,
   output logic signed [DATA_W-1:0] data_o
);

   localparam int MAG_W = DATA_W + 1;
   localparam logic [MAG_W-1:0] LIMIT = MAG_W'(CLIP_LEVEL);

   logic signed [MAG_W-1:0] ext;
   logic        [MAG_W-1:0] mag;

   always_comb begin
      ext = {data_i[DATA_W-1], data_i};
      mag = ext[MAG_W-1] ? MAG_W'(-ext) : MAG_W'(ext);
      if (en_i && (mag < LIMIT)) begin
         data_o = DATA_W'(1);
      end else begin
         data_o = data_i;
      end
   end

   always_comb begin
      AST_CLIP_NONZERO: assert (!en_i || data_o != '0); // R6
   end

endmodule

// File: rtl/slp_gain.sv
module slp_gain
   import slp_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter bit GAIN_SAT = 1'b1
) (
   input  logic [1:0]               code_i,
   input  logic signed [DATA_W-1:0] data_i,
   output logic signed [DATA_W-1:0] data_o
);

   localparam int XW = DATA_W + MAX_STEP;
   localparam logic signed [XW-1:0] POS_MAX = XW'((64'sd1 <<< (DATA_W-1)) - 1);
   localparam logic signed [XW-1:0] NEG_MIN = -XW'(64'sd1 <<< (DATA_W-1));

   logic signed [XW-1:0] wide;

   always_comb begin
      wide = XW'(data_i) <<< lvl_steps(code_i);
   end

   generate
      if (GAIN_SAT) begin : g_sat
         always_comb begin
            if (wide > POS_MAX) begin
               data_o = {1'b0, {(DATA_W-1){1'b1}}};
            end else if (wide < NEG_MIN) begin
               data_o = {1'b1, {(DATA_W-1){1'b0}}};
            end else begin
               data_o = wide[DATA_W-1:0];
            end
         end

         always_comb begin
            AST_NO_WRAP: assert (data_i == '0 || data_o[DATA_W-1] == data_i[DATA_W-1]); // R3
         end
      end else begin : g_wrap
         always_comb begin
            data_o = wide[DATA_W-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/slp_clear_gen.sv
module slp_clear_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic bypass_i,
   output logic clear_o
);

   logic clr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clr_q <= 1'b0;
      end else begin
         clr_q <= bypass_i;
      end
   end

   assign clear_o = clr_q;

   AST_CLEAR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bypass_i) |=> clear_o); // R8

   AST_CLEAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bypass_i) |=> !clear_o); // R8

endmodule

// File: rtl/slp_send_level.sv
module slp_send_level #(
   parameter int DATA_W     = 16,
   parameter int CLIP_LEVEL = 46,
   parameter bit GAIN_SAT   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sin_valid_i,
   input  logic signed [DATA_W-1:0] sin_data_i,
   input  logic [1:0]               att_code_i,
   input  logic [1:0]               gain_code_i,
   input  logic                     clip_en_i,
   input  logic                     bypass_i,
   output logic                     fwd_valid_o,
   output logic signed [DATA_W-1:0] fwd_data_o,
   input  logic                     res_valid_i,
   input  logic signed [DATA_W-1:0] res_data_i,
   output logic                     coef_clear_o,
   output logic                     sout_valid_o,
   output logic signed [DATA_W-1:0] sout_data_o
);

   localparam longint FULL_SCALE = (64'sd1 <<< (DATA_W-1)) - 1;

   generate
      if (DATA_W < 4 || DATA_W > 32) begin : g_bad_width
         $error("slp_send_level: DATA_W must lie in 4..32");
      end
      if (CLIP_LEVEL < 1 || CLIP_LEVEL > FULL_SCALE) begin : g_bad_clip
         $error("slp_send_level: CLIP_LEVEL outside the sample range");
      end
   endgenerate

   logic                     att_vld;
   logic signed [DATA_W-1:0] att_data;
   logic                     sel_vld;
   logic signed [DATA_W-1:0] sel_data;
   logic signed [DATA_W-1:0] clip_data;
   logic signed [DATA_W-1:0] gain_data;
   logic                     out_vld_q;
   logic signed [DATA_W-1:0] out_data_q;

   slp_atten #(.DATA_W(DATA_W)) u_atten (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (sin_valid_i),
      .data_i (sin_data_i),
      .code_i (att_code_i),
      .vld_o  (att_vld),
      .data_o (att_data)
   );

   always_comb begin
      if (bypass_i) begin
         sel_vld  = att_vld;
         sel_data = att_data;
      end else begin
         sel_vld  = res_valid_i;
         sel_data = res_data_i;
      end
   end

   slp_clip #(.DATA_W(DATA_W), .CLIP_LEVEL(CLIP_LEVEL)) u_clip (
      .en_i   (clip_en_i),
      .data_i (sel_data),
      .data_o (clip_data)
   );

   slp_gain #(.DATA_W(DATA_W), .GAIN_SAT(GAIN_SAT)) u_gain (
      .code_i (gain_code_i),
      .data_i (clip_data),
      .data_o (gain_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld_q  <= 1'b0;
         out_data_q <= '0;
      end else begin
         out_vld_q <= sel_vld;
         if (sel_vld) begin
            out_data_q <= gain_data;
         end
      end
   end

   slp_clear_gen u_clear (
      .clk      (clk),
      .rst_n    (rst_n),
      .bypass_i (bypass_i),
      .clear_o  (coef_clear_o)
   );

   assign fwd_valid_o  = att_vld;
   assign fwd_data_o   = att_data;
   assign sout_valid_o = out_vld_q;
   assign sout_data_o  = out_data_q;

   AST_BYPASS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass_i && att_vld) |=> sout_valid_o); // R4

   AST_RESIDUAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass_i && res_valid_i) |=> sout_valid_o); // R5

   AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass_i ? !att_vld : !res_valid_i) |=> !sout_valid_o); // R5

   AST_CLIP_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_vld && clip_en_i) |=> (sout_data_o != '0)); // R6

endmodule

// File: tb/slp_send_level_tb.sv
module slp_send_level_tb_top;

   localparam int W = 16;

   typedef struct packed {
      logic                byp;
      logic [1:0]          att;
      logic [1:0]          gn;
      logic                clp;
      logic signed [W-1:0] din;
      logic signed [W-1:0] exp;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 2'd0, 2'd0, 1'b0,  16'sd1000,   16'sd1000},  // R1 0 dB
      '{1'b1, 2'd1, 2'd0, 1'b0,  16'sd1000,   16'sd500},   // R1 -6 dB
      '{1'b1, 2'd2, 2'd0, 1'b0, -16'sd1001,  -16'sd251},   // R1 -12 dB, floor
      '{1'b1, 2'd3, 2'd0, 1'b0,  16'sd1000,   16'sd1000},  // R1 reserved
      '{1'b1, 2'd0, 2'd1, 1'b0,  16'sd1000,   16'sd2000},  // R2 +6 dB
      '{1'b1, 2'd0, 2'd2, 1'b0,  16'sd1000,   16'sd4000},  // R2 +12 dB
      '{1'b1, 2'd0, 2'd2, 1'b0,  16'sd10000,  16'sd32767}, // R3 high rail
      '{1'b1, 2'd0, 2'd2, 1'b0, -16'sd10000, -16'sd32768}, // R3 low rail
      '{1'b1, 2'd0, 2'd3, 1'b0,  16'sd1000,   16'sd1000},  // R2 reserved
      '{1'b1, 2'd1, 2'd1, 1'b0,  16'sd1001,   16'sd1000},  // R4 both codes apply
      '{1'b0, 2'd0, 2'd0, 1'b1,  16'sd45,     16'sd1},     // R6 below level
      '{1'b0, 2'd0, 2'd0, 1'b1, -16'sd45,     16'sd1},     // R6 negative below
      '{1'b0, 2'd0, 2'd0, 1'b1,  16'sd46,     16'sd46},    // R6 at level
      '{1'b0, 2'd0, 2'd0, 1'b1, -16'sd46,    -16'sd46},    // R6 negative at level
      '{1'b0, 2'd0, 2'd1, 1'b1,  16'sd10,     16'sd2},     // R6 clip then boost
      '{1'b0, 2'd0, 2'd0, 1'b0,  16'sd10,     16'sd10},    // R7 no clip
      '{1'b0, 2'd0, 2'd1, 1'b0, -16'sd32768, -16'sd32768}, // R3 most negative
      '{1'b1, 2'd2, 2'd0, 1'b1,  16'sd100,    16'sd1},     // R6 in bypass
      '{1'b0, 2'd0, 2'd0, 1'b0,  16'sd0,      16'sd0},     // R7 zero kept
      '{1'b0, 2'd0, 2'd2, 1'b0,  16'sd8192,   16'sd32767}  // R3 edge overflow
   };

   logic                clk = 1'b0;
   logic                rst_n;
   logic                sin_valid;
   logic signed [W-1:0] sin_data;
   logic [1:0]          att_code;
   logic [1:0]          gain_code;
   logic                clip_en;
   logic                bypass;
   logic                fwd_valid;
   logic signed [W-1:0] fwd_data;
   logic                res_valid;
   logic signed [W-1:0] res_data;
   logic                coef_clear;
   logic                sout_valid;
   logic signed [W-1:0] sout_data;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   slp_send_level dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .sin_valid_i  (sin_valid),
      .sin_data_i   (sin_data),
      .att_code_i   (att_code),
      .gain_code_i  (gain_code),
      .clip_en_i    (clip_en),
      .bypass_i     (bypass),
      .fwd_valid_o  (fwd_valid),
      .fwd_data_o   (fwd_data),
      .res_valid_i  (res_valid),
      .res_data_i   (res_data),
      .coef_clear_o (coef_clear),
      .sout_valid_o (sout_valid),
      .sout_data_o  (sout_data)
   );

   task automatic check(input string req, input logic signed [W-1:0] act,
                        input logic signed [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL R9: watchdog expired, actual hung expected done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; sin_valid = 1'b0; sin_data = '0; att_code = '0;
      gain_code = '0; clip_en = 1'b0; bypass = 1'b0;
      res_valid = 1'b0; res_data = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 sout_valid", W'(sout_valid), 0);
      check("R9 fwd_valid", W'(fwd_valid), 0);
      check("R9 sout_data", sout_data, 0);
      check("R9 coef_clear", W'(coef_clear), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         att_code = VEC[i].att; gain_code = VEC[i].gn;
         clip_en = VEC[i].clp; bypass = VEC[i].byp;
         if (VEC[i].byp) begin
            sin_data = VEC[i].din; sin_valid = 1'b1;
            @(negedge clk);
            sin_valid = 1'b0;
            @(negedge clk);
         end else begin
            res_data = VEC[i].din; res_valid = 1'b1;
            @(negedge clk);
            res_valid = 1'b0;
         end
         check($sformatf("vector %0d valid (R4/R5)", i), W'(sout_valid), 1);
         check($sformatf("vector %0d data (R1-R7 table)", i), sout_data, VEC[i].exp);
         @(negedge clk);
      end

      // R1 and R5: near-end sample in normal mode goes to canceller only
      bypass = 1'b0; att_code = 2'd1; gain_code = 2'd0; clip_en = 1'b0;
      @(negedge clk);
      sin_data = -16'sd7; sin_valid = 1'b1;
      @(negedge clk);
      sin_valid = 1'b0;
      check("R1 fwd_valid", W'(fwd_valid), 1);
      check("R1 fwd_data", fwd_data, -16'sd4);
      @(negedge clk);
      check("R5 no output without residual", W'(sout_valid), 0);

      // R8 clear request timing
      bypass = 1'b1;
      check("R8 clear not yet", W'(coef_clear), 0);
      @(negedge clk);
      check("R8 clear raised", W'(coef_clear), 1);
      repeat (3) @(negedge clk);
      check("R8 clear held", W'(coef_clear), 1);

      // R4 residual ignored in bypass
      res_data = 16'sd1234; res_valid = 1'b1;
      @(negedge clk);
      res_valid = 1'b0;
      check("R4 residual ignored", W'(sout_valid), 0);

      // R10 bypass latency
      att_code = 2'd0; sin_data = 16'sd321; sin_valid = 1'b1;
      @(negedge clk);
      sin_valid = 1'b0;
      check("R10 not after one clock", W'(sout_valid), 0);
      @(negedge clk);
      check("R10 valid after two clocks", W'(sout_valid), 1);
      check("R10 data", sout_data, 16'sd321);

      bypass = 1'b0;
      @(negedge clk);
      check("R8 clear released", W'(coef_clear), 0);

      // R9 reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 reset clears data", sout_data, 0);
      check("R9 reset clears valid", W'(sout_valid), 0);
      finish_run();
   end

endmodule